// File: doc/BRIEF.md
# Input Over-Power Fault Integrator

This block models, in the digital domain, the timer that protects the adapter input switch against sustained power stress. While the input current limiter reports that it is limiting, an accumulator climbs once per time tick by an amount proportional to a supplied code for the voltage drop across the switch. Current times voltage is therefore integrated as an energy proxy. When the limiter is idle, the accumulator bleeds down by a fixed amount per tick and stops at zero.

When the accumulator reaches a programmable threshold, a sticky fault flag is set and the switch enable is forced low. Only two events clear the fault and the accumulator: loss of the adapter-detect flag, or the undervoltage lockout flag.

A short blanking window opens a fixed number of ticks after adapter detect rises. It lets the inrush current limit act without tripping the latch. Inside the window, limiting does not raise the accumulator, and no latch can occur.

Top module: `inpwr_fault_latch`

## Requirements
- R1: In reset, `acc_o` is 0 and `fault_o` is 0.
- R2: On a tick, with `limiting_i` high, no fault and no blanking, `acc_o` rises by GAIN × `drop_code_i`, saturating at 2^ACC_W − 1.
- R3: On a tick with `limiting_i` low and no fault, `acc_o` falls by LEAK, or goes to 0 if it holds LEAK or less.
- R4: `acc_o` changes only on ticks or on a clear. A tick is one clock in every TICK_DIV, counted from reset release, starting on the TICK_DIV-th clock.
- R5: `fault_o` is set on the same tick on which the updated accumulator is at least THRESH, outside the blanking window.
- R6: Once set, `fault_o` stays high and `acc_o` is frozen for as long as `adapter_ok_i` is high and `uvlo_i` is low.
- R7: While `adapter_ok_i` is low or `uvlo_i` is high, `acc_o` and `fault_o` go to 0 on the next clock.
- R8: Ticks are counted from the moment `adapter_ok_i` rises; the count is held at 0 while the flag is low. A tick whose count of earlier ticks lies in [BLANK_DELAY, BLANK_DELAY + BLANK_LEN) is blanked. On a blanked tick, limiting holds `acc_o` unchanged and no fault is set; a blanked tick without limiting still leaks.
- R9: `switch_en_o` is high exactly when `adapter_ok_i` is high, `uvlo_i` is low and `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| limiting_i | input | 1 | Input current limiter is active |
| drop_code_i | input | DROP_W | Voltage drop across the input switch, unsigned code |
| adapter_ok_i | input | 1 | Adapter detected |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| fault_o | output | 1 | Over-power fault latched |
| switch_en_o | output | 1 | Adapter switch allowed on |
| acc_o | output | ACC_W | Stress accumulator value |

## Verification
The integrator is driven through several distinct patterns:
- A slow ramp with a small drop code, then an idle leak, which separates the rise rate from the bleed rate.
- A large drop code that must clip at full scale and latch on a single tick.
- Continued limiting after a latch, which shows the value frozen and the fault sticky.
- Separate undervoltage and adapter-loss pulses, each of which must clear the fault.
- A case that charges the accumulator just before the blanking window and then limits hard inside it. The value must hold and the fault must stay clear until the first tick after the window, where it trips at once.

// File: rtl/inpwr_pkg.sv
// Package: shared types for the input over-power integrator.
// Assumes: nothing beyond IEEE 1800-2017.
package inpwr_pkg;

    // Update applied to the accumulator in a given clock.
    typedef enum logic [1:0] {
        UPD_CLEAR = 2'd0,
        UPD_HOLD  = 2'd1,
        UPD_RISE  = 2'd2,
        UPD_LEAK  = 2'd3
    } acc_upd_e;

    // Bit width that holds values 0..v (at least 1).
    function automatic int unsigned width_for(input longint unsigned v);
        int unsigned w;
        w = 1;
        while ((longint'(1) << w) <= v) w++;
        return w;
    endfunction

endpackage

// File: rtl/inpwr_tick_gen.sv
// Module: free-running tick divider.
// Emits a one-clock tick every DIV clocks, the first on the DIV-th clock
// after reset release. Assumes DIV >= 1.
module inpwr_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    import inpwr_pkg::*;

    generate
        if (DIV <= 1) begin : g_every_clock
            assign tick_o = 1'b1;
        end else begin : g_divided
            localparam int unsigned CW = width_for(DIV - 1);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Count 0..DIV-1 and wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt_q <= '0;
                else if (cnt_q == LAST)  cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/inpwr_blank_timer.sv
// Module: blanking window after adapter detect.
// Counts ticks while adapter_ok_i is high and holds the count at zero while it is
// low, so every rising edge restarts it. The count saturates once past the window.
// blank_o flags counts in [DELAY, DELAY+LEN). Assumes the ticks come from inpwr_tick_gen.
module inpwr_blank_timer #(
    parameter int unsigned DELAY = 700,
    parameter int unsigned LEN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic adapter_ok_i,
    output logic blank_o
);
    import inpwr_pkg::*;

    localparam int unsigned END_CNT = DELAY + LEN;
    localparam int unsigned CW      = width_for(END_CNT);
    localparam logic [CW-1:0] START_V = CW'(DELAY);
    localparam logic [CW-1:0] END_V   = CW'(END_CNT);

    logic [CW-1:0] cnt_q;

    // Tick counter since adapter detect, saturating at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || !adapter_ok_i)       cnt_q <= '0;
        else if (tick_i && cnt_q < END_V)  cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (LEN == 0) begin : g_no_window
            assign blank_o = 1'b0;
        end else begin : g_window
            assign blank_o = (cnt_q >= START_V) && (cnt_q < END_V);
        end
    endgenerate
endmodule

// File: rtl/inpwr_integrator.sv
// Module: stress accumulator and fault latch.
// On ticks: rises by GAIN*drop while limiting (unless blanked), and leaks by LEAK
// otherwise, with a floor at zero. It latches a fault at THRESH and freezes while
// latched. clear_i zeroes both. Assumes THRESH < 2**ACC_W.
module inpwr_integrator #(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned DROP_W = 8,
    parameter int unsigned GAIN   = 18,
    parameter int unsigned LEAK   = 5,
    parameter int unsigned THRESH = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clear_i,
    input  logic              limiting_i,
    input  logic              blank_i,
    input  logic [DROP_W-1:0] drop_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              fault_o
);
    import inpwr_pkg::*;

    localparam int unsigned INC_W = DROP_W + width_for(GAIN);
    localparam int unsigned SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;
    localparam logic [INC_W-1:0] GAIN_V = INC_W'(GAIN);
    localparam logic [SUM_W-1:0] FULL_V = (SUM_W'(1) << ACC_W) - SUM_W'(1);
    localparam logic [ACC_W-1:0] LEAK_V = ACC_W'(LEAK);
    localparam logic [ACC_W-1:0] TH_V   = ACC_W'(THRESH);

    logic [ACC_W-1:0] acc_q, acc_d;
    logic             fault_q, fault_d;
    logic [INC_W-1:0] inc;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] risen, leaked;
    acc_upd_e         upd;

    // Choose the update for this clock.
    always_comb begin
        if (clear_i)                  upd = UPD_CLEAR;
        else if (!tick_i || fault_q)  upd = UPD_HOLD;
        else if (limiting_i)          upd = blank_i ? UPD_HOLD : UPD_RISE;
        else                          upd = UPD_LEAK;
    end

    // Saturating rise and floored leak candidates.
    always_comb begin
        inc    = GAIN_V * INC_W'(drop_i);
        sum    = SUM_W'(acc_q) + SUM_W'(inc);
        risen  = (sum > FULL_V) ? ACC_W'(FULL_V) : ACC_W'(sum);
        leaked = (acc_q > LEAK_V) ? (acc_q - LEAK_V) : '0;
    end

    // Next accumulator and fault state.
    always_comb begin
        acc_d   = acc_q;
        fault_d = fault_q;
        unique case (upd)
            UPD_CLEAR: begin
                acc_d   = '0;
                fault_d = 1'b0;
            end
            UPD_RISE: begin
                acc_d   = risen;
                fault_d = (risen >= TH_V);
            end
            UPD_LEAK:  acc_d = leaked;
            default:   acc_d = acc_q;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            fault_q <= fault_d;
        end
    end

    assign acc_o   = acc_q;
    assign fault_o = fault_q;
endmodule

// File: rtl/inpwr_fault_latch.sv
// Module: top of the input over-power fault integrator.
// Ties the tick divider, the blanking timer and the integrator together, and gates
// the adapter switch enable. Assumes the inputs are synchronous to clk.
module inpwr_fault_latch #(
    parameter int unsigned ACC_W       = 16,
    parameter int unsigned DROP_W      = 8,
    parameter int unsigned GAIN        = 18,
    parameter int unsigned LEAK        = 5,
    parameter int unsigned THRESH      = 20000,
    parameter int unsigned TICK_DIV    = 125000,
    parameter int unsigned BLANK_DELAY = 700,
    parameter int unsigned BLANK_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              limiting_i,
    input  logic [DROP_W-1:0] drop_code_i,
    input  logic              adapter_ok_i,
    input  logic              uvlo_i,
    output logic              fault_o,
    output logic              switch_en_o,
    output logic [ACC_W-1:0]  acc_o
);
    logic tick_w;
    logic blank_w;
    logic clear_w;

    // Loss of adapter or supply clears the latch.
    assign clear_w = !adapter_ok_i || uvlo_i;

    inpwr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    inpwr_blank_timer #(.DELAY(BLANK_DELAY), .LEN(BLANK_LEN)) u_blank (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .adapter_ok_i (adapter_ok_i),
        .blank_o      (blank_w)
    );

    inpwr_integrator #(
        .ACC_W  (ACC_W),
        .DROP_W (DROP_W),
        .GAIN   (GAIN),
        .LEAK   (LEAK),
        .THRESH (THRESH)
    ) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_w),
        .clear_i    (clear_w),
        .limiting_i (limiting_i),
        .blank_i    (blank_w),
        .drop_i     (drop_code_i),
        .acc_o      (acc_o),
        .fault_o    (fault_o)
    );

    // Switch allowed only with adapter, good supply and no fault.
    assign switch_en_o = adapter_ok_i && !uvlo_i && !fault_o;
endmodule

// File: rtl/inpwr_fault_latch_chk.sv
// Module: property checker bound to inpwr_fault_latch.
// Observes the ports plus the tick and blank strobes from the sub-blocks.
module inpwr_fault_latch_chk #(
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned THRESH = 20000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adapter_ok_i,
    input logic             uvlo_i,
    input logic             fault_o,
    input logic [ACC_W-1:0] acc_o,
    input logic             tick_w,
    input logic             blank_w
);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adapter_ok_i || uvlo_i) |=> (acc_o == '0 && !fault_o));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && adapter_ok_i && !uvlo_i) |=> fault_o);

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && adapter_ok_i && !uvlo_i) |=> $stable(acc_o));

    assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_w && adapter_ok_i && !uvlo_i) |=> $stable(acc_o));

    assert_trip_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> (acc_o >= ACC_W'(THRESH)));

    assert_blank_no_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && blank_w && !fault_o && adapter_ok_i && !uvlo_i) |=> !fault_o);
endmodule

bind inpwr_fault_latch inpwr_fault_latch_chk #(
    .ACC_W  (ACC_W),
    .THRESH (THRESH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adapter_ok_i (adapter_ok_i),
    .uvlo_i       (uvlo_i),
    .fault_o      (fault_o),
    .acc_o        (acc_o),
    .tick_w       (tick_w),
    .blank_w      (blank_w)
);

// File: tb/inpwr_fault_latch_tb.sv
module inpwr_fault_latch_tb;
    localparam int ACC_W = 12, DROP_W = 8, GAIN = 18, LEAK = 5, THRESH = 600;
    localparam int DIV = 4, DELAY = 12, BLEN = 5;
    localparam int FULL = (1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic limiting = 1'b0;
    logic [DROP_W-1:0] drop_code = '0;
    logic adapter_ok = 1'b0;
    logic uvlo = 1'b0;
    logic fault, sw_en;
    logic [ACC_W-1:0] acc;

    int checks = 0, fails = 0;
    int m_acc = 0, m_fault = 0, m_presc = 0, m_cnt = 0, m_tick = 0;

    always #4 clk = ~clk;

    inpwr_fault_latch #(
        .ACC_W(ACC_W), .DROP_W(DROP_W), .GAIN(GAIN), .LEAK(LEAK), .THRESH(THRESH),
        .TICK_DIV(DIV), .BLANK_DELAY(DELAY), .BLANK_LEN(BLEN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .limiting_i(limiting), .drop_code_i(drop_code),
        .adapter_ok_i(adapter_ok), .uvlo_i(uvlo), .fault_o(fault),
        .switch_en_o(sw_en), .acc_o(acc)
    );

    task automatic expect_int(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Behavioural reference, one clock edge.
    task automatic model_edge();
        int blank;
        if (!rst_n) begin
            m_acc = 0; m_fault = 0; m_presc = 0; m_cnt = 0; m_tick = 0;
            return;
        end
        m_tick  = (m_presc == DIV - 1);
        m_presc = m_tick ? 0 : m_presc + 1;
        blank   = (m_cnt >= DELAY) && (m_cnt < DELAY + BLEN);
        if (!adapter_ok) m_cnt = 0;
        else if (m_tick && m_cnt < DELAY + BLEN) m_cnt++;
        if (!adapter_ok || uvlo) begin
            m_acc = 0; m_fault = 0;
        end else if (m_tick && !m_fault) begin
            if (limiting && !blank) begin
                m_acc = m_acc + GAIN * int'(drop_code);
                if (m_acc > FULL) m_acc = FULL;
                if (m_acc >= THRESH) m_fault = 1;
            end else if (!limiting) begin
                m_acc = (m_acc > LEAK) ? m_acc - LEAK : 0;
            end
        end
    endtask

    task automatic step(input string tag, input logic lim, input int drop,
                        input logic ad, input logic uv);
        limiting = lim; drop_code = drop[DROP_W-1:0]; adapter_ok = ad; uvlo = uv;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        expect_int(tag, "acc", int'(acc), m_acc);
        expect_int(tag, "fault", int'(fault), m_fault);
        expect_int("R9", "switch_en", int'(sw_en), int'(ad && !uv && m_fault == 0));
    endtask

    task automatic tick_step(input string tag, input logic lim, input int drop);
        step(tag, lim, drop, 1'b1, 1'b0);
        while (m_tick == 0) step(tag, lim, drop, 1'b1, 1'b0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (4) step("R1", 1'b1, 200, 1'b0, 1'b0);
        expect_int("R1", "reset acc", int'(acc), 0);
        rst_n = 1'b1;
        repeat (10) step("R7", 1'b1, 200, 1'b0, 1'b0);
        // adapter up, idle past the blanking window
        while (m_cnt < DELAY + BLEN) step("R8", 1'b0, 0, 1'b1, 1'b0);
        repeat (3) tick_step("R3", 1'b0, 0);
        expect_int("R3", "floor", int'(acc), 0);
        repeat (5) tick_step("R2", 1'b1, 3);
        expect_int("R2", "ramp 5x54", int'(acc), 270);
        repeat (5) tick_step("R3", 1'b0, 0);
        expect_int("R3", "leak 5x5", int'(acc), 245);
        tick_step("R5", 1'b1, 10);
        expect_int("R5", "below threshold", int'(fault), 0);
        tick_step("R5", 1'b1, 10);
        expect_int("R5", "trip acc", int'(acc), 605);
        expect_int("R5", "trip fault", int'(fault), 1);
        repeat (4) tick_step("R6", 1'b1, 255);
        expect_int("R6", "frozen acc", int'(acc), 605);
        expect_int("R6", "sticky fault", int'(fault), 1);
        step("R7", 1'b0, 0, 1'b1, 1'b1);
        expect_int("R7", "uvlo clear", int'(acc), 0);
        step("R7", 1'b0, 0, 1'b1, 1'b0);
        tick_step("R2", 1'b1, 255);
        expect_int("R2", "saturate", int'(acc), FULL);
        expect_int("R5", "saturate trip", int'(fault), 1);
        step("R7", 1'b0, 0, 1'b0, 1'b0);
        expect_int("R7", "adapter loss clear", int'(fault), 0);
        // blanking: charge just before the window, then limit hard inside it
        while (m_cnt < DELAY - 3) step("R8", 1'b0, 0, 1'b1, 1'b0);
        repeat (2) tick_step("R8", 1'b1, 5);
        expect_int("R8", "pre-window ramp", int'(acc), 180);
        tick_step("R8", 1'b0, 0);
        expect_int("R8", "pre-window leak", int'(acc), 175);
        while (m_cnt < DELAY + BLEN) step("R8", 1'b1, 255, 1'b1, 1'b0);
        expect_int("R8", "window hold", int'(acc), 175);
        expect_int("R8", "window no trip", int'(fault), 0);
        tick_step("R5", 1'b1, 255);
        expect_int("R5", "post-window trip", int'(fault), 1);
        repeat (6) step("R4", 1'b0, 0, 1'b1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule